// File: doc/BRIEF.md
# PCM Bit-Clock and Frame-Sync Generator with Idle Gap

This block is the timing master of a PCM audio bus. It divides a fast system clock down to a bit clock and counts bit periods from the start of each frame. It marks bit period zero with a frame-sync pulse. Inside each frame it holds the emitted bit clock low over a programmable window of bit positions. As a result, a frame contains fewer bit-clock edges than its length in bit periods. A transmit-window flag tells the neighbouring serializer when it may shift data. The flag drops once the idle window is reached and stays low for the rest of the frame.

Software, or a neighbouring block, sets the half-period divider, the frame length, the idle start and end positions, and a polarity bit. These values are taken straight from the input ports. They should only be changed while the enable is low. Dropping the enable parks all outputs at their inactive level. Raising it again starts a new frame at bit position zero.

Top module: `pcm_bclk_gen`

## Requirements
- R1: While rst_ni is low, bclk_o, fsync_o and tx_win_o are all 0.
- R2: With en_i high, each half of a bit period lasts div_i+1 system cycles. A bit period opens with its low half, followed by the high half.
- R3: The bit position starts at 0 when enabled and advances by one at the end of each bit period. It wraps to 0 after frame_len_i-1. The active frame-sync level is present for exactly bit position 0.
- R4: Gating is in effect when the effective idle end is greater than idle_start_i. The effective idle end is idle_end_i, limited to at most frame_len_i. While gating is in effect, the active bit clock is 0 for bit positions p with idle_start_i <= p < effective end.
- R5: With frame length 100, idle start 60 and idle end 90, exactly 70 rising active bit-clock edges occur between consecutive frame-sync pulses.
- R6: tx_win_o is 1 exactly when enabled and either gating is off or the bit position is below idle_start_i.
- R7: inv_i=1 inverts bclk_o and fsync_o: the emitted value is the active value XOR inv_i. tx_win_o is never inverted.
- R8: An idle_end_i less than or equal to idle_start_i turns gating off. All frame_len_i clock pulses are then emitted.
- R9: An idle_end_i above frame_len_i acts as frame_len_i, so the clock stays quiet to the end of the frame.
- R10: The gating decision only changes in a cycle where the active bit clock is 0, so no shortened clock pulse is produced.
- R11: With en_i low, the outputs are inactive one cycle later: active clock 0, active frame-sync 0, tx_win_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| en_i | input | 1 | run enable; low parks outputs and restarts the frame |
| div_i | input | DIV_W | half bit period minus one, in system cycles |
| frame_len_i | input | POS_W | bit periods per frame (at least 1) |
| idle_start_i | input | POS_W | first bit position of the idle window |
| idle_end_i | input | POS_W | bit position where the idle window ends |
| inv_i | input | 1 | polarity: inverts bclk_o and fsync_o |
| bclk_o | output | 1 | gated bit clock |
| fsync_o | output | 1 | frame-sync pulse |
| tx_win_o | output | 1 | serializer may shift data |

## Verification
All three outputs come from flops loaded with the next-state value. Any change of enable, prescaler or position is therefore visible one system cycle after the clock edge that takes it in. The bench reference model updates its counters on that same edge and compares all outputs at the following falling edge. Stimulus is driven just after a falling edge, so a new configuration or enable takes effect at the next rising edge. Its result is checked at the falling edge after that. The edge-count checks read a count that is latched at each frame-sync rise, so they compare whole frames only.

// File: rtl/pcm_bclk_pkg.sv
package pcm_bclk_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } bclk_phase_e;
endpackage

// File: rtl/pcm_bclk_prescale.sv
module pcm_bclk_prescale
  import pcm_bclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_i,
  output bclk_phase_e      phase_n_o,
  output logic             bit_end_o
);
  logic [DIV_W-1:0] cnt_q, cnt_n;
  bclk_phase_e      phase_q, phase_n;
  logic             half_done;

  assign half_done = (cnt_q >= half_i);

  always_comb begin
    cnt_n     = cnt_q;
    phase_n   = phase_q;
    bit_end_o = 1'b0;
    if (!en_i) begin
      cnt_n   = '0;
      phase_n = PH_LOW;
    end else if (half_done) begin
      cnt_n = '0;
      if (phase_q == PH_HIGH) begin
        phase_n   = PH_LOW;
        bit_end_o = 1'b1;
      end else begin
        phase_n = PH_HIGH;
      end
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= PH_LOW;
    end else begin
      cnt_q   <= cnt_n;
      phase_q <= phase_n;
    end
  end

  assign phase_n_o = phase_n;
endmodule

// File: rtl/pcm_frame_pos.sv
module pcm_frame_pos #(
  parameter int POS_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bit_end_i,
  input  logic [POS_W-1:0] len_i,
  output logic [POS_W-1:0] pos_n_o,
  output logic [POS_W-1:0] pos_q_o
);
  logic [POS_W-1:0] pos_q, pos_n;
  logic             pos_ce;
  logic             last_bit;

  assign last_bit = (pos_q >= len_i - 1'b1);
  assign pos_ce   = bit_end_i || !en_i;

  always_comb begin
    if (!en_i || last_bit) pos_n = '0;
    else                   pos_n = pos_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (pos_ce) pos_q <= pos_n;
  end

  assign pos_n_o = pos_ce ? pos_n : pos_q;
  assign pos_q_o = pos_q;
endmodule

// File: rtl/pcm_idle_decode.sv
module pcm_idle_decode #(
  parameter int POS_W = 10
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic [POS_W-1:0] len_i,
  input  logic [POS_W-1:0] start_i,
  input  logic [POS_W-1:0] stop_i,
  output logic             gate_o,
  output logic             tx_ok_o
);
  logic [POS_W-1:0] stop_eff;
  logic             gate_on;

  always_comb begin
    stop_eff = (stop_i > len_i) ? len_i : stop_i;
    gate_on  = (stop_eff > start_i);
    gate_o   = gate_on && (pos_i >= start_i) && (pos_i < stop_eff);
    tx_ok_o  = !gate_on || (pos_i < start_i);
  end
endmodule

// File: rtl/pcm_bclk_gen.sv
module pcm_bclk_gen
  import pcm_bclk_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int POS_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [POS_W-1:0] frame_len_i,
  input  logic [POS_W-1:0] idle_start_i,
  input  logic [POS_W-1:0] idle_end_i,
  input  logic             inv_i,
  output logic             bclk_o,
  output logic             fsync_o,
  output logic             tx_win_o
);
  bclk_phase_e      phase_n;
  logic             bit_end;
  logic [POS_W-1:0] pos_n, pos_q;
  logic             gate, tx_ok;
  logic             bclk_n, fsync_n, tx_n;
  logic             bclk_q, fsync_q, tx_q;

  pcm_bclk_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .half_i    (div_i),
    .phase_n_o (phase_n),
    .bit_end_o (bit_end)
  );

  pcm_frame_pos #(.POS_W(POS_W)) u_pos (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .bit_end_i (bit_end),
    .len_i     (frame_len_i),
    .pos_n_o   (pos_n),
    .pos_q_o   (pos_q)
  );

  pcm_idle_decode #(.POS_W(POS_W)) u_idle (
    .pos_i   (pos_n),
    .len_i   (frame_len_i),
    .start_i (idle_start_i),
    .stop_i  (idle_end_i),
    .gate_o  (gate),
    .tx_ok_o (tx_ok)
  );

  // Outputs are loaded from next-state values; gating follows the position,
  // which only moves when the next phase is low.
  always_comb begin
    bclk_n  = ((phase_n == PH_HIGH) && !gate) ^ inv_i;
    fsync_n = (en_i && (pos_n == '0)) ^ inv_i;
    tx_n    = en_i && tx_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q  <= 1'b0;
      fsync_q <= 1'b0;
      tx_q    <= 1'b0;
    end else begin
      bclk_q  <= bclk_n;
      fsync_q <= fsync_n;
      tx_q    <= tx_n;
    end
  end

  assign bclk_o   = bclk_q;
  assign fsync_o  = fsync_q;
  assign tx_win_o = tx_q;
endmodule

// File: rtl/pcm_bclk_gen_chk.sv
module pcm_bclk_gen_chk #(
  parameter int POS_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [POS_W-1:0] frame_len_i,
  input logic [POS_W-1:0] idle_start_i,
  input logic [POS_W-1:0] idle_end_i,
  input logic             inv_i,
  input logic             bclk_o,
  input logic             fsync_o,
  input logic             tx_win_o,
  input logic [POS_W-1:0] pos_q
);
  logic             inv_d, en_d;
  logic [POS_W-1:0] len_d, st_d, end_d, end_eff;
  logic             on_d, in_idle, b_act, f_act;

  always_ff @(posedge clk_i) begin
    inv_d <= inv_i;
    en_d  <= en_i;
    len_d <= frame_len_i;
    st_d  <= idle_start_i;
    end_d <= idle_end_i;
  end

  assign end_eff = (end_d > len_d) ? len_d : end_d;
  assign on_d    = end_eff > st_d;
  assign in_idle = on_d && (pos_q >= st_d) && (pos_q < end_eff);
  assign b_act   = bclk_o ^ inv_d;
  assign f_act   = fsync_o ^ inv_d;

  // R4
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_idle |-> !b_act);
  // R10
  gate_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_idle != $past(in_idle)) |-> !b_act);
  // R6
  tx_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_win_o |-> (!on_d || (pos_q < st_d)));
  // R3
  fsync_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_act |-> (pos_q == '0));
  // R11
  parked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_d |-> (!tx_win_o && !b_act && !f_act));
endmodule

bind pcm_bclk_gen pcm_bclk_gen_chk #(.POS_W(POS_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .frame_len_i  (frame_len_i),
  .idle_start_i (idle_start_i),
  .idle_end_i   (idle_end_i),
  .inv_i        (inv_i),
  .bclk_o       (bclk_o),
  .fsync_o      (fsync_o),
  .tx_win_o     (tx_win_o),
  .pos_q        (pos_q)
);

// File: tb/tb_pcm_bclk_gen.sv
module tb_pcm_bclk_gen;
  localparam int DIV_W = 8;
  localparam int POS_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic [POS_W-1:0] len = 10'd100, st = 10'd60, stop = 10'd90;
  logic inv = 1'b0;
  logic bclk, fsync, txw;

  always #10 clk = ~clk;

  pcm_bclk_gen #(.DIV_W(DIV_W), .POS_W(POS_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .div_i(div),
    .frame_len_i(len), .idle_start_i(st), .idle_end_i(stop), .inv_i(inv),
    .bclk_o(bclk), .fsync_o(fsync), .tx_win_o(txw)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  function automatic void chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endfunction

  // reference model state
  int m_rst = 1, m_pre = 0, m_ph = 0, m_pos = 0;
  int m_en = 0, m_inv = 0, m_len = 1, m_st = 0, m_end = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rst = 1; m_pre = 0; m_ph = 0; m_pos = 0;
    end else begin
      m_rst = 0;
      m_en = en; m_inv = inv; m_len = len; m_st = st; m_end = stop;
      if (!en) begin
        m_pre = 0; m_ph = 0; m_pos = 0;
      end else if (m_pre >= int'(div)) begin
        m_pre = 0;
        if (m_ph == 1) begin
          m_ph = 0;
          m_pos = (m_pos + 1 >= m_len) ? 0 : m_pos + 1;
        end else begin
          m_ph = 1;
        end
      end else begin
        m_pre++;
      end
    end
  end

  // per-cycle comparison and frame edge monitor
  int edge_cnt = 0, last_edges = 0, frames = 0;
  bit prev_b = 0, prev_f = 0;

  always @(negedge clk) begin
    int ee;
    bit gon, idle, eb, ef, et, ba, fa;
    ee   = (m_end > m_len) ? m_len : m_end;
    gon  = ee > m_st;
    idle = gon && m_pos >= m_st && m_pos < ee;
    eb = m_rst ? 1'b0 : (((m_ph == 1) && !idle) ^ m_inv[0]);
    ef = m_rst ? 1'b0 : (((m_en != 0) && m_pos == 0) ^ m_inv[0]);
    et = m_rst ? 1'b0 : ((m_en != 0) && (!gon || m_pos < m_st));
    chk(bclk == eb, m_rst ? "R1" : "R4", bclk, eb);
    chk(fsync == ef, m_rst ? "R1" : "R3", fsync, ef);
    chk(txw == et, m_rst ? "R1" : "R6", txw, et);
    ba = bclk ^ m_inv[0];
    fa = fsync ^ m_inv[0];
    if (fa && !prev_f) begin
      last_edges = edge_cnt;
      edge_cnt = 0;
      frames++;
    end
    if (ba && !prev_b) edge_cnt++;
    prev_b = ba;
    prev_f = fa;
  end

  task automatic wait_frames(int n);
    int target;
    target = frames + n;
    while (frames < target) @(negedge clk);
  endtask

  task automatic run_cfg(int d, int l, int s, int e, bit iv, int exp, string req);
    @(negedge clk); #1;
    en = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    div = d[DIV_W-1:0]; len = l[POS_W-1:0]; st = s[POS_W-1:0];
    stop = e[POS_W-1:0]; inv = iv;
    repeat (2) @(negedge clk);
    #1;
    en = 1'b1;
    wait_frames(3);
    chk(last_edges == exp, req, last_edges, exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs held low in reset (also compared each cycle)
    chk(bclk == 0 && fsync == 0 && txw == 0, "R1", {bclk, fsync, txw}, 0);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: parked while disabled
    chk(txw == 0 && bclk == inv, "R11", {bclk, txw}, {inv, 1'b0});

    // R5: 100-period frame, quiet 60..89 -> 70 edges
    run_cfg(0, 100, 60, 90, 1'b0, 70, "R5");
    // R2 R4: slower divider, short frame, 8 - (6-3) = 5 edges
    run_cfg(2, 8, 3, 6, 1'b0, 5, "R2");
    // R8: end below start turns gating off
    run_cfg(0, 100, 60, 40, 1'b0, 100, "R8");
    // R9: end beyond frame clamps to frame end
    run_cfg(0, 100, 60, 150, 1'b0, 60, "R9");
    // R7: inverted polarity, 10 - 3 = 7 active edges
    run_cfg(1, 10, 4, 7, 1'b1, 7, "R7");
    // R4 R6: whole frame idle -> no edges
    run_cfg(0, 20, 0, 20, 1'b0, 0, "R4");
    // R10: idle window starting at 1 with fast divider
    run_cfg(0, 12, 1, 11, 1'b0, 2, "R10");

    // R11: drop enable mid-frame, then restart at position 0
    run_cfg(1, 8, 3, 6, 1'b0, 5, "R3");
    repeat (13) @(negedge clk);
    #1 en = 1'b0;
    @(negedge clk);
    chk(txw == 0 && bclk == 0 && fsync == 0, "R11", {bclk, fsync, txw}, 0);
    repeat (4) @(negedge clk);
    #1 en = 1'b1;
    @(negedge clk);
    // R3: restart opens a frame with frame-sync active
    chk(fsync == 1, "R3", fsync, 1);
    wait_frames(2);
    chk(last_edges == 5, "R3", last_edges, 5);

    #1 en = 1'b0;
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule